// File: doc/BRIEF.md
# Debug Serial Packet Responder

This block is the target end of a synchronous, full-duplex serial debug link. The host owns the serial clock. Every transfer moves 17 bits each way, most significant bit first. The host sends a flag bit and a 16-bit word. At the same time the block returns a status bit and a 16-bit word that encodes the current result from the command handler.

The serial clock and data are resynchronised into the core clock. Input bits are taken on each rising serial clock edge. The outgoing bit moves on each falling edge.

When the 17th bit arrives, the block presents the received word and flag to the command handler for one core clock. It also raises an error pulse if the host set the flag bit. It then stays busy for a fixed recovery gap and ignores any serial activity during that gap.

The command handler offers a result as a valid level, a kind code and a data word. The block takes that result at the first rising serial edge of a transfer and acknowledges it. If no result is offered at that point, it answers with the not-ready code on its own.

Top module: `dbgp_responder`

## Requirements
- R1: A transfer consists of 17 rising serial clock edges, and the bits are taken most significant first. The first bit is the host flag and the next 16 are the word. `rx_stb` pulses for exactly one core clock, on the third core clock after the 17th rising serial edge is applied, with `rx_word` and `rx_ctrl` valid in that same cycle.
- R2: The response is driven on `dbg_sdo` as a status bit followed by 16 data bits, MSB first. Each falling serial edge advances to the next bit. The encoding depends on `rsp_kind`:
  - kind 0 (data): status 0, data = `rsp_data`
  - kind 1 (ok): status 0, data 0xFFFF
  - kind 2 (not ready): status 1, data 0x0000
  - kind 3 (bus error): status 1, data 0x0001
  - kind 4 (illegal command): status 1, data 0xFFFF
- R3: If `rsp_valid` is low when a transfer starts, the response is the not-ready code: status 1, data 0x0000.
- R4: `rsp_take` pulses for one core clock at the start of a transfer, and only if the response was offered with `rsp_valid` high. It stays low for transfers answered automatically.
- R5: `rx_ctrl` carries the received flag bit. `ctrl_err` pulses together with `rx_stb` exactly when that flag bit is 1.
- R6: `busy` rises in the same cycle as `rx_stb` and stays high for exactly 32 core clocks (the parameter `GAP_CYC`).
- R7: Serial clock edges that arrive while `busy` is high have no effect. They produce no strobe and do not advance the bit position of the next transfer.
- R8: After reset, `rx_stb`, `ctrl_err`, `rsp_take` and `busy` are low.
- R9: `rsp_kind` values 5, 6 and 7 are encoded as an illegal command: status 1, data 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sclk | input | 1 | Serial clock from host |
| dbg_sdi | input | 1 | Serial data from host |
| dbg_sdo | output | 1 | Serial data to host (registered) |
| rsp_valid | input | 1 | Handler has a result to send |
| rsp_kind | input | 3 | Result kind code (see R2, R9) |
| rsp_data | input | 16 | Result word for kind 0 |
| rsp_take | output | 1 | Result taken at transfer start |
| rx_stb | output | 1 | Received packet strobe |
| rx_ctrl | output | 1 | Received flag bit |
| rx_word | output | 16 | Received data word |
| ctrl_err | output | 1 | Received flag bit was set |
| busy | output | 1 | Recovery gap in progress |

## Verification
Every serial edge passes through two synchroniser stages and an edge register before the shift logic acts on it. As a result, `rx_stb`, `rsp_take` and the `busy` rise all appear on the third core clock after the bench applies a serial edge. The bench applies all inputs just after a falling core clock edge and counts falling edges from that point, so each strobe is compared on exactly the third one.

The bench checks `busy` on every cycle of the gap. It requires the value to stay high for 32 consecutive samples and to be low on the next.

Each response bit is read just before the host raises the serial clock. That is at least five core clocks after the shift caused by the previous falling serial edge, so every bit has settled when it is read.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  typedef enum logic [2:0] {
    KIND_DATA     = 3'd0,
    KIND_OK       = 3'd1,
    KIND_NOTREADY = 3'd2,
    KIND_BUSERR   = 3'd3,
    KIND_ILLEGAL  = 3'd4
  } rsp_kind_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } link_state_e;
endpackage

// File: rtl/dbgp_sync.sv
module dbgp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbgp_encoder.sv
module dbgp_encoder #(
  parameter int WORD_W = 16
) (
  input  logic              valid,
  input  logic [2:0]        kind,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W:0]   pkt
);
  import dbgp_pkg::*;

  always_comb begin
    if (!valid) begin
      pkt = {1'b1, {WORD_W{1'b0}}};
    end else begin
      case (rsp_kind_e'(kind))
        KIND_DATA:     pkt = {1'b0, data};
        KIND_OK:       pkt = {1'b0, {WORD_W{1'b1}}};
        KIND_NOTREADY: pkt = {1'b1, {WORD_W{1'b0}}};
        KIND_BUSERR:   pkt = {1'b1, {(WORD_W-1){1'b0}}, 1'b1};
        default:       pkt = {1'b1, {WORD_W{1'b1}}};
      endcase
    end
  end
endmodule

// File: rtl/dbgp_gap.sv
module dbgp_gap #(
  parameter int GAP_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(GAP_CYC + 1);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      left_q <= CNT_W'(GAP_CYC - 1);
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else left_q <= left_q - 1'b1;
    end
  end

  assert_busy_on_start_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: rtl/dbgp_responder.sv
module dbgp_responder #(
  parameter int WORD_W      = 16,
  parameter int GAP_CYC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_sclk,
  input  logic              dbg_sdi,
  output logic              dbg_sdo,
  input  logic              rsp_valid,
  input  logic [2:0]        rsp_kind,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              rsp_take,
  output logic              rx_stb,
  output logic              rx_ctrl,
  output logic [WORD_W-1:0] rx_word,
  output logic              ctrl_err,
  output logic              busy
);
  import dbgp_pkg::*;

  localparam int PKT_W = WORD_W + 1;
  localparam int CNT_W = $clog2(PKT_W + 1);

  logic [1:0]        pin_s;
  logic              sclk_s, sdi_s, sclk_d;
  logic              rise, fall, last_bit;
  logic [PKT_W-1:0]  enc_pkt, tx_q;
  logic [WORD_W-1:0] rx_sh;
  logic [CNT_W-1:0]  bit_cnt;
  logic              lat_valid;
  link_state_e       state;

  dbgp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({dbg_sclk, dbg_sdi}), .q(pin_s));

  assign sclk_s = pin_s[1];
  assign sdi_s  = pin_s[0];
  assign rise   = sclk_s & ~sclk_d;
  assign fall   = ~sclk_s & sclk_d;
  assign last_bit = (state == ST_SHIFT) && rise && (bit_cnt == CNT_W'(PKT_W - 1));

  dbgp_encoder #(.WORD_W(WORD_W)) u_enc (
    .valid(rsp_valid), .kind(rsp_kind), .data(rsp_data), .pkt(enc_pkt));

  dbgp_gap #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst(rst), .start(last_bit), .busy(busy));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sclk_d    <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_q      <= '0;
      lat_valid <= 1'b0;
      rsp_take  <= 1'b0;
      rx_stb    <= 1'b0;
      rx_ctrl   <= 1'b0;
      rx_word   <= '0;
      ctrl_err  <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      rsp_take <= 1'b0;
      rx_stb   <= 1'b0;
      ctrl_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!busy) begin
            if (rise) begin
              state    <= ST_SHIFT;
              rx_sh    <= {rx_sh[WORD_W-2:0], sdi_s};
              bit_cnt  <= CNT_W'(1);
              rsp_take <= lat_valid;
            end else begin
              tx_q      <= enc_pkt;
              lat_valid <= rsp_valid;
            end
          end
        end
        default: begin
          if (rise) begin
            rx_sh   <= {rx_sh[WORD_W-2:0], sdi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              state    <= ST_IDLE;
              bit_cnt  <= '0;
              rx_stb   <= 1'b1;
              rx_ctrl  <= rx_sh[WORD_W-1];
              ctrl_err <= rx_sh[WORD_W-1];
              rx_word  <= {rx_sh[WORD_W-2:0], sdi_s};
            end
          end else if (fall) begin
            tx_q <= {tx_q[PKT_W-2:0], 1'b0};
          end
        end
      endcase
    end
  end

  assign dbg_sdo = tx_q[PKT_W-1];

  assert_stb_single_R1: assert property (@(posedge clk) disable iff (rst)
    rx_stb |=> !rx_stb);
  assert_err_with_stb_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl_err |-> rx_stb);
  assert_stb_busy_R6: assert property (@(posedge clk) disable iff (rst)
    rx_stb |-> busy);
  assert_auto_notready_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !busy && !rise && !rsp_valid) |=> tx_q == {1'b1, {WORD_W{1'b0}}});
  assert_take_single_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_take |=> !rsp_take);
  assert_gap_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !rx_stb);
endmodule

// File: tb/test_dbgp_responder.sv
`timescale 1ns/1ps
module test_dbgp_responder;
  localparam int GAP = 32;
  localparam int HP  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_sclk = 1'b0, dbg_sdi = 1'b0;
  logic        dbg_sdo;
  logic        rsp_valid = 1'b0;
  logic [2:0]  rsp_kind = 3'd0;
  logic [15:0] rsp_data = 16'h0;
  logic        rsp_take, rx_stb, rx_ctrl, ctrl_err, busy;
  logic [15:0] rx_word;

  int checks = 0, failures = 0, take_cnt = 0, stb_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbgp_responder i_dbgp_responder (
    .clk(clk), .rst(rst), .dbg_sclk(dbg_sclk), .dbg_sdi(dbg_sdi), .dbg_sdo(dbg_sdo),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .rsp_take(rsp_take), .rx_stb(rx_stb), .rx_ctrl(rx_ctrl), .rx_word(rx_word),
    .ctrl_err(ctrl_err), .busy(busy));

  always @(posedge clk) begin
    if (rsp_take) take_cnt++;
    if (rx_stb) stb_cnt++;
  end

  function automatic logic [16:0] exp_rsp(input logic v, input logic [2:0] k, input logic [15:0] d);
    if (!v) return {1'b1, 16'h0000};
    case (k)
      3'd0: return {1'b0, d};
      3'd1: return {1'b0, 16'hFFFF};
      3'd2: return {1'b1, 16'h0000};
      3'd3: return {1'b1, 16'h0001};
      default: return {1'b1, 16'hFFFF};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [16:0] pkt, input logic v, input logic [2:0] k,
                      input logic [15:0] d, input bit stray, input string req);
    logic [16:0] got, exp;
    int take0, stb0, busy_run;
    exp = exp_rsp(v, k, d);
    @(negedge clk);
    rsp_valid = v; rsp_kind = k; rsp_data = d;
    repeat (4) @(negedge clk);
    take0 = take_cnt;
    for (int i = 16; i >= 0; i--) begin
      dbg_sdi = pkt[i];
      repeat (HP) @(negedge clk);
      got[i] = dbg_sdo;
      dbg_sclk = 1'b1;
      if (i == 16) begin
        repeat (4) @(negedge clk);
        rsp_valid = 1'b0;
        repeat (HP - 4) @(negedge clk);
        dbg_sclk = 1'b0;
      end else if (i > 0) begin
        repeat (HP) @(negedge clk);
        dbg_sclk = 1'b0;
      end else begin
        stb0 = stb_cnt;
        busy_run = 0;
        for (int n = 1; n <= GAP + 3; n++) begin
          @(negedge clk);
          if (n == HP) dbg_sclk = 1'b0;
          if (stray && (n == 12 || n == 20)) dbg_sclk = 1'b1;
          if (stray && (n == 16 || n == 24)) dbg_sclk = 1'b0;
          if (n == 3) begin
            chk(rx_stb === 1'b1, "R1", "strobe", {31'd0, rx_stb}, 1);
            chk(rx_word === pkt[15:0], "R1", "rx_word", {16'd0, rx_word}, {16'd0, pkt[15:0]});
            chk(rx_ctrl === pkt[16], "R5", "rx_ctrl", {31'd0, rx_ctrl}, {31'd0, pkt[16]});
            chk(ctrl_err === pkt[16], "R5", "ctrl_err", {31'd0, ctrl_err}, {31'd0, pkt[16]});
          end
          if (n == 4) chk(rx_stb === 1'b0, "R1", "strobe width", {31'd0, rx_stb}, 0);
          if (n >= 3 && n <= GAP + 2 && busy === 1'b1) busy_run++;
          if (n == GAP + 3) begin
            chk(busy === 1'b0, "R6", "busy after gap", {31'd0, busy}, 0);
            chk(busy_run == GAP, "R6", "busy length", busy_run, GAP);
          end
        end
        chk(stb_cnt == stb0 + 1, "R7", "strobes in gap", stb_cnt - stb0, 1);
      end
    end
    chk(got === exp, req, "response", {15'd0, got}, {15'd0, exp});
    chk(take_cnt == take0 + (v ? 1 : 0), "R4", "take count", take_cnt - take0, v ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_stb === 1'b0, "R8", "reset rx_stb", {31'd0, rx_stb}, 0);
    chk(ctrl_err === 1'b0, "R8", "reset ctrl_err", {31'd0, ctrl_err}, 0);
    chk(rsp_take === 1'b0, "R8", "reset rsp_take", {31'd0, rsp_take}, 0);
    chk(busy === 1'b0, "R8", "reset busy", {31'd0, busy}, 0);
    xfer(17'h0A5C3, 1'b1, 3'd0, 16'h1234, 1'b0, "R2");
    xfer(17'h00000, 1'b1, 3'd1, 16'h0000, 1'b0, "R2");
    xfer(17'h0FFFF, 1'b1, 3'd2, 16'h5555, 1'b0, "R2");
    xfer(17'h08001, 1'b1, 3'd3, 16'hAAAA, 1'b0, "R2");
    xfer(17'h00001, 1'b1, 3'd4, 16'h0F0F, 1'b0, "R2");
    xfer(17'h13C3C, 1'b1, 3'd6, 16'h0000, 1'b0, "R9");
    xfer(17'h0BEEF, 1'b0, 3'd0, 16'hFFFF, 1'b1, "R3");
    xfer(17'h1FFFF, 1'b1, 3'd0, 16'hFFFF, 1'b1, "R7");
    for (int t = 0; t < 50; t++) begin
      logic [16:0] p;
      logic        v;
      p = {($urandom % 5 == 0) ? 1'b1 : 1'b0, 16'($urandom)};
      v = ($urandom % 4 != 0);
      xfer(p, v, 3'($urandom), 16'($urandom), ($urandom % 3 == 0), v ? "R2" : "R3");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule